// File: doc/BRIEF.md
# Systematic Polar Codeword Encoder

This block turns an 11-bit message into a 16-bit polar codeword in which the message can be read back directly. The message bits appear unchanged at eleven fixed information positions, and the polar pre-transform vector is zero at the remaining five frozen positions. The encoding takes two passes through the same XOR network. The message is first scattered onto the information positions, with zeros everywhere else, and transformed once. The frozen positions of that result are then cleared, and the vector is transformed a second time. The output is the codeword.

Upstream logic presents a message with a valid/ready handshake. Each accepted message yields exactly one codeword, which is registered and flagged valid in the following cycle. Both passes sit in one combinational path, so the encoder takes a new message on every cycle, and the code length, message width and frozen pattern are parameters.

Top module: `polar_sys_encoder`

## Requirements
- R1: `in_ready` is low while `rst` is high and from the first clock edge after reset release stays high. A message is accepted on any rising edge where `in_valid` and `in_ready` are both high.
- R2: `out_valid` is high for exactly the cycle after each accepted message and low after any edge without an acceptance. Back-to-back acceptances give back-to-back valid codewords.
- R3: The information positions are 3, 5, 6, 7, 9, 10, 11, 12, 13, 14 and 15. Message bit k (bit 0 = LSB of `in_msg`) appears unchanged at the k-th of these positions in ascending order, e.g. message bit 0 at codeword bit 3 and message bit 10 at codeword bit 15.
- R4: The frozen positions are 0, 1, 2, 4 and 8. Applying the polar transform to `out_code` gives zero at every frozen position.
- R5: The polar transform T maps v to x with x[j] equal to the XOR of v[i] over all i whose set bits include every set bit of j, which is the product with the 4-fold Kronecker power of [[1,0],[1,1]]. `out_code` equals T(Z(T(P(m)))), where P places the message per R3 and Z clears the frozen positions.
- R6: On an edge without an acceptance, `out_code` keeps its value, whatever `in_msg` carries.
- R7: After reset, `out_valid` is 0 and `out_code` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Message present on `in_msg` |
| in_ready | output | 1 | Encoder can accept a message |
| in_msg | input | 11 | Message to encode |
| out_valid | output | 1 | One-cycle flag: `out_code` holds a new codeword |
| out_code | output | 16 | Registered systematic codeword |

## Verification
The encoder holds no state between messages, so a wrong internal value shows in the very codeword registered on the edge that accepts the message. A misrouted butterfly stage or a wrong rank in the message placement shows up as a message bit missing from its information position. A missed or misplaced frozen clear shows up as a non-zero frozen bit after the codeword is run back through the transform. Every one of the 2048 messages is encoded, and each codeword is compared against an independent matrix-style computation the cycle after it is accepted. Idle cycles between messages confirm that the output register neither changes nor flags valid.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;

  // Default configuration of the systematic encoder: N = 2**PE_N_LOG.
  localparam int PE_N_LOG = 4;
  localparam int PE_MSG_W = 11;
  // Bit i set means position i is frozen (positions 0, 1, 2, 4, 8).
  localparam logic [(2**PE_N_LOG)-1:0] PE_FROZEN = 16'h0117;

endpackage

// File: rtl/polar_info_scatter.sv
module polar_info_scatter #(
  parameter int N_LOG = 4,
  parameter int MSG_W = 11,
  parameter logic [(2**N_LOG)-1:0] FROZEN_MASK = 16'h0117
) (
  input  logic [MSG_W-1:0]        msg,
  output logic [(2**N_LOG)-1:0]   vec
);
  localparam int N = 2 ** N_LOG;

  // Number of information positions strictly below pos.
  function automatic int info_rank(input int pos);
    int r;
    r = 0;
    for (int p = 0; p < pos; p++) begin
      if (!FROZEN_MASK[p]) r++;
    end
    return r;
  endfunction

  for (genvar j = 0; j < N; j++) begin : g_pos
    if (FROZEN_MASK[j]) begin : g_frozen
      assign vec[j] = 1'b0;
    end else begin : g_info
      localparam int RANK = info_rank(j);
      assign vec[j] = msg[RANK];
    end
  end

endmodule

// File: rtl/polar_butterfly.sv
module polar_butterfly #(
  parameter int N_LOG = 4
) (
  input  logic [(2**N_LOG)-1:0] din,
  output logic [(2**N_LOG)-1:0] dout
);
  localparam int N = 2 ** N_LOG;

  // stage[s] is the vector after s butterfly levels.
  logic [N_LOG:0][N-1:0] stage;

  assign stage[0] = din;

  for (genvar s = 0; s < N_LOG; s++) begin : g_level
    localparam int STRIDE = 2 ** s;
    for (genvar i = 0; i < N; i++) begin : g_lane
      if (((i / STRIDE) % 2) == 0) begin : g_upper
        assign stage[s+1][i] = stage[s][i] ^ stage[s][i+STRIDE];
      end else begin : g_lower
        assign stage[s+1][i] = stage[s][i];
      end
    end
  end

  assign dout = stage[N_LOG];

endmodule

// File: rtl/polar_frozen_clear.sv
module polar_frozen_clear #(
  parameter int N_LOG = 4,
  parameter logic [(2**N_LOG)-1:0] FROZEN_MASK = 16'h0117
) (
  input  logic [(2**N_LOG)-1:0] din,
  output logic [(2**N_LOG)-1:0] dout
);
  localparam int N = 2 ** N_LOG;

  for (genvar j = 0; j < N; j++) begin : g_pos
    if (FROZEN_MASK[j]) begin : g_zero
      assign dout[j] = 1'b0;
    end else begin : g_keep
      assign dout[j] = din[j];
    end
  end

endmodule

// File: rtl/polar_sys_encoder.sv
module polar_sys_encoder
  import polar_enc_pkg::*;
#(
  parameter int N_LOG = PE_N_LOG,
  parameter int MSG_W = PE_MSG_W,
  parameter logic [(2**N_LOG)-1:0] FROZEN_MASK = PE_FROZEN
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [MSG_W-1:0]        in_msg,
  output logic                    out_valid,
  output logic [(2**N_LOG)-1:0]   out_code
);
  localparam int N = 2 ** N_LOG;

  // Named internal events, visible to the bound checker.
  logic         ready_q;
  logic         accept;
  logic [N-1:0] placed_vec;
  logic [N-1:0] pass1_vec;
  logic [N-1:0] pass2_in;
  logic [N-1:0] code_next;

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  polar_info_scatter #(
    .N_LOG(N_LOG), .MSG_W(MSG_W), .FROZEN_MASK(FROZEN_MASK)
  ) u_scatter (
    .msg(in_msg),
    .vec(placed_vec)
  );

  polar_butterfly #(.N_LOG(N_LOG)) u_pass1 (
    .din(placed_vec),
    .dout(pass1_vec)
  );

  polar_frozen_clear #(.N_LOG(N_LOG), .FROZEN_MASK(FROZEN_MASK)) u_clear (
    .din(pass1_vec),
    .dout(pass2_in)
  );

  polar_butterfly #(.N_LOG(N_LOG)) u_pass2 (
    .din(pass2_in),
    .dout(code_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      ready_q   <= 1'b1;
      out_valid <= accept;
      if (accept) out_code <= code_next;
    end
  end

endmodule

// File: rtl/polar_sys_encoder_chk.sv
module polar_sys_encoder_chk #(
  parameter int N_LOG = 4,
  parameter int MSG_W = 11,
  parameter logic [(2**N_LOG)-1:0] FROZEN_MASK = 16'h0117
) (
  input logic                  clk,
  input logic                  rst,
  input logic [MSG_W-1:0]      in_msg,
  input logic                  out_valid,
  input logic [(2**N_LOG)-1:0] out_code,
  input logic                  accept,
  input logic [(2**N_LOG)-1:0] code_next
);
  localparam int N = 2 ** N_LOG;

  // Subset-sum form of the polar transform.
  function automatic logic [N-1:0] subset_xform(input logic [N-1:0] v);
    logic [N-1:0] r;
    r = '0;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        if ((i & j) == j) r[j] = r[j] ^ v[i];
      end
    end
    return r;
  endfunction

  function automatic logic [MSG_W-1:0] gather_info(input logic [N-1:0] v);
    logic [MSG_W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int j = 0; j < N; j++) begin
      if (!FROZEN_MASK[j]) begin
        if (k < MSG_W) r[k] = v[j];
        k++;
      end
    end
    return r;
  endfunction

  assert_valid_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !out_valid);

  assert_info_bits_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (gather_info(out_code) == $past(in_msg)));

  assert_frozen_zero_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((subset_xform(out_code) & FROZEN_MASK) == '0));

  assert_next_code_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    accept |-> ((subset_xform(code_next) & FROZEN_MASK) == '0));

  assert_hold_code_R6: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(out_code));

  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && (out_code == '0)));

endmodule

bind polar_sys_encoder polar_sys_encoder_chk #(
  .N_LOG(N_LOG), .MSG_W(MSG_W), .FROZEN_MASK(FROZEN_MASK)
) u_chk (
  .clk(clk),
  .rst(rst),
  .in_msg(in_msg),
  .out_valid(out_valid),
  .out_code(out_code),
  .accept(accept),
  .code_next(code_next)
);

// File: tb/test_polar_sys_encoder.sv
module test_polar_sys_encoder;

  localparam int N = 16;
  localparam int K = 11;
  localparam logic [N-1:0] FROZEN = 16'h0117;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [K-1:0] in_msg = '0;
  logic         out_valid;
  logic [N-1:0] out_code;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  polar_sys_encoder i_polar_sys_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_msg(in_msg), .out_valid(out_valid), .out_code(out_code)
  );

  // Generator-matrix form: G[i][j] = 1 when j's bits are a subset of i's.
  function automatic logic [N-1:0] gen_mult(input logic [N-1:0] u);
    logic [N-1:0] x;
    for (int j = 0; j < N; j++) begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < N; i++) acc = acc ^ (u[i] & ((i | j) == i));
      x[j] = acc;
    end
    return x;
  endfunction

  function automatic logic [N-1:0] ref_encode(input logic [K-1:0] m);
    logic [N-1:0] u;
    int k;
    u = '0;
    k = 0;
    for (int j = 0; j < N; j++) begin
      if (!FROZEN[j]) begin
        u[j] = m[k];
        k++;
      end
    end
    return gen_mult(gen_mult(u) & ~FROZEN);
  endfunction

  function automatic logic [K-1:0] info_of(input logic [N-1:0] c);
    logic [K-1:0] r;
    int k;
    k = 0;
    r = '0;
    for (int j = 0; j < N; j++) begin
      if (!FROZEN[j]) begin
        r[k] = c[j];
        k++;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] last_code;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R7 code in reset", {16'd0, out_code}, 32'd0);
    check("R1 ready in reset", {31'd0, in_ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, in_ready}, 32'd1);
    check("R7 valid after reset", {31'd0, out_valid}, 32'd0);

    // Spot values: message bit 0 -> codeword bit 3, bit 10 -> bit 15.
    last_code = '0;
    for (int m = 0; m < (1 << K); m++) begin
      logic [N-1:0] exp_code;
      in_valid = 1'b1;
      in_msg   = m[K-1:0];
      exp_code = ref_encode(m[K-1:0]);
      @(negedge clk);
      check("R2 valid after accept", {31'd0, out_valid}, 32'd1);
      check("R5 codeword", {16'd0, out_code}, {16'd0, exp_code});
      check("R3 info bits", {21'd0, info_of(out_code)}, {21'd0, m[K-1:0]});
      check("R4 frozen after inverse", {16'd0, gen_mult(out_code) & FROZEN}, 32'd0);
      check("R1 ready stays high", {31'd0, in_ready}, 32'd1);
      last_code = exp_code;
      if ((m % 97) == 5) begin
        in_valid = 1'b0;
        in_msg   = ~m[K-1:0];
        @(negedge clk);
        check("R2 no valid when idle", {31'd0, out_valid}, 32'd0);
        check("R6 code held when idle", {16'd0, out_code}, {16'd0, last_code});
        @(negedge clk);
        check("R6 code held second idle", {16'd0, out_code}, {16'd0, last_code});
      end
    end
    in_valid = 1'b0;
    in_msg   = 11'h7FF;
    @(negedge clk);
    check("R2 valid drops at end", {31'd0, out_valid}, 32'd0);
    check("R6 final hold", {16'd0, out_code}, {16'd0, last_code});
    // Single bit check: message 1 places a one at position 3.
    check("R3 unit message position", {21'd0, info_of(ref_encode(11'd1))}, 32'd1);
    finish_run();
  end

endmodule